// File: doc/BRIEF.md
# Host Register Access and Output-Enable Control

This block sits between a host microprocessor bus and the time-slot switching core of a TDM switch. A 15-bit host address, together with a select strobe and a write flag, reaches five kinds of storage. The data memory can only be read, and it sits outside this block: reads are forwarded to it. The connection memory is held here and can be read and written. The block also holds a control register and eight frame-offset registers. A frame-align status value, supplied from outside, can only be read. Read data returns one clock after the request, marked by a valid strobe.

The same block decides, for every output stream and for the channel slot the switching core is currently sending, whether the transmit line is driven. Four inputs settle that decision:

- a per-channel high-impedance code held in the connection memory;
- the global enable pin;
- a standby-release bit in the control register;
- two indication modes.

In the half-stream indication mode, odd streams report the drive state of their even partner and carry no data. In the all-stream indication mode, the device serves as the three-state controller for a twin switch, and every line reports its own stream's drive state.

Top module: `tsw_host_oe`

## Requirements
- R1: Address bits 14:13 = 2'b10 select the connection memory, with the stream in bits 12:8 and the channel in bits 7:0. A write stores the 16-bit word. A read returns it on h_rdata, with h_rvalid high, in the cycle after the request.
- R2: Address bits 14:13 = 2'b01 select registers by code in bits 12:9. Code 0 is the 16-bit control register. Codes 2 to 9 are frame-offset registers 0 to 7. All of them are read/write, and a written value appears on ctrl_out and on ofs_out (register k at bits 16k+15:16k) from the cycle after the write.
- R3: Register code 1 returns falign_in and ignores writes. Bits 14:13 = 2'b11 forward a read to the external data memory: dm_re is pulsed and dm_addr carries address bits 12:0. h_rdata then returns dm_rdata one cycle later. Writes to the data memory are ignored.
- R4: Register codes 10 to 15, area 2'b00, and connection-memory addresses whose stream is at or above NUM_STREAMS or whose channel is at or above NUM_CHANNELS all read as zero and ignore writes.
- R5: Reset clears the control and offset registers and drives tx_oe, tx_ind, tx_is_ind and h_rvalid low. Reset leaves the connection-memory contents unchanged.
- R6: If the connection-memory word at (stream, tx_slot) has bits 15:14 = 2'b11, that stream is not driven in normal mode, whatever ode and the standby bit are.
- R7: Otherwise a stream is driven exactly when ode or control bit 0 (standby release) is 1.
- R8: With control bit 1 set and bit 2 clear, even streams behave as in R6/R7. Each odd stream 2k+1 is driven whenever ode or bit 0 is set, has tx_is_ind high, and carries on tx_ind the drive state of stream 2k.
- R9: With control bit 2 set, whatever bit 1 holds, every stream is driven whenever ode or bit 0 is set, has tx_is_ind high, and carries its own drive state on tx_ind.
- R10: tx_oe, tx_ind and tx_is_ind are registered: they reflect tx_slot, ode and the control bits as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | 1 = write, 0 = read |
| h_addr | input | 15 | Host address |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data |
| h_rvalid | output | 1 | Read data valid |
| dm_re | output | 1 | Read request to the external data memory |
| dm_addr | output | 13 | Stream and channel of the data-memory read |
| dm_rdata | input | 16 | Data-memory word, one cycle after dm_re |
| falign_in | input | 16 | Frame-align status value |
| ctrl_out | output | 16 | Control register contents |
| ofs_out | output | 128 | Eight frame-offset registers, packed |
| ode | input | 1 | Global output enable pin |
| tx_slot | input | 5 | Channel slot now being transmitted |
| tx_oe | output | 4 | Per-stream line drive enable |
| tx_ind | output | 4 | Indication value for lines in an indication mode |
| tx_is_ind | output | 4 | Line carries indication instead of data |

## Verification
The output-enable properties assume that tx_slot always stays below NUM_CHANNELS, and that every connection-memory word in use has been written before ode or the standby bit is raised. This is because reset leaves that memory undefined. The stimulus meets both conditions. It writes every stream and channel while ode and the standby bit are low, and it steps tx_slot only through valid channels. The read-path properties assume one access per h_sel pulse. The host driver releases the strobe after each cycle.

// File: rtl/tsw_host_pkg.sv
package tsw_host_pkg;

    localparam int ADDR_W  = 15;
    localparam int DATA_W  = 16;
    localparam int NUM_OFS = 8;

    typedef enum logic [1:0] {
        AREA_NONE = 2'b00,
        AREA_REG  = 2'b01,
        AREA_CM   = 2'b10,
        AREA_DM   = 2'b11
    } area_e;

    localparam logic [3:0] RC_CTRL      = 4'd0;
    localparam logic [3:0] RC_FALIGN    = 4'd1;
    localparam logic [3:0] RC_OFS_FIRST = 4'd2;
    localparam logic [3:0] RC_OFS_LAST  = 4'd9;

    localparam int CTRL_OSB = 0;
    localparam int CTRL_OEI = 1;
    localparam int CTRL_AOE = 2;

    localparam logic [1:0] CM_MODE_HIZ = 2'b11;

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic       is_ctrl;
        logic       is_falign;
        logic       is_ofs;
        logic [2:0] ofs_idx;
        logic       is_cm;
        logic       is_dm;
        logic [4:0] strm;
        logic [7:0] chan;
    } hreq_t;

    typedef struct packed {
        logic [DATA_W-1:0]              ctrl;
        logic [NUM_OFS-1:0][DATA_W-1:0] ofs;
        logic                           rvalid;
        logic                           rsrc_dm;
        logic [DATA_W-1:0]              rdata;
    } regs_st_t;

endpackage

// File: rtl/tsw_addr_decode.sv
module tsw_addr_decode
    import tsw_host_pkg::*;
#(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 32
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output hreq_t             req
);

    logic [3:0] code;
    assign code = addr[12:9];

    always_comb begin
        req      = '0;
        req.rd   = sel && !we;
        req.wr   = sel && we;
        req.strm = addr[12:8];
        req.chan = addr[7:0];
        case (area_e'(addr[14:13]))
            AREA_DM: req.is_dm = 1'b1;
            AREA_CM: req.is_cm = (int'(addr[12:8]) < NUM_STREAMS) &&
                                 (int'(addr[7:0]) < NUM_CHANNELS);
            AREA_REG: begin
                if (code == RC_CTRL) begin
                    req.is_ctrl = 1'b1;
                end else if (code == RC_FALIGN) begin
                    req.is_falign = 1'b1;
                end else if (code >= RC_OFS_FIRST && code <= RC_OFS_LAST) begin
                    req.is_ofs  = 1'b1;
                    req.ofs_idx = 3'(code - RC_OFS_FIRST);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tsw_connmem.sv
module tsw_connmem
    import tsw_host_pkg::*;
#(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 32,
    localparam int DEPTH    = NUM_STREAMS * NUM_CHANNELS,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CH_IDX_W = $clog2(NUM_CHANNELS)
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic                   rd_ok,
    input  logic [4:0]             strm,
    input  logic [7:0]             chan,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    input  logic [CH_IDX_W-1:0]    slot_chan,
    output logic [NUM_STREAMS-1:0] slot_hiz
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  h_idx;

    assign h_idx = IDX_W'(int'(strm) * NUM_CHANNELS + int'(chan));
    assign rdata = rd_ok ? mem_q[h_idx] : '0;

    // Storage is deliberately left out of reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[h_idx] <= wdata;
        end
    end

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_slot
        logic [DATA_W-1:0] word;
        assign word        = mem_q[IDX_W'(s * NUM_CHANNELS + int'(slot_chan))];
        assign slot_hiz[s] = (word[DATA_W-1 -: 2] == CM_MODE_HIZ);
    end

endmodule

// File: rtl/tsw_host_regs.sv
module tsw_host_regs
    import tsw_host_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  hreq_t                          req,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [DATA_W-1:0]              falign_in,
    input  logic [DATA_W-1:0]              cm_rdata,
    output logic [DATA_W-1:0]              ctrl_q,
    output logic [NUM_OFS-1:0][DATA_W-1:0] ofs_q,
    output logic                           rvalid_q,
    output logic                           rsrc_dm_q,
    output logic [DATA_W-1:0]              rdata_q
);

    regs_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.rvalid  = req.rd;
        st_d.rsrc_dm = req.rd && req.is_dm;
        st_d.rdata   = '0;
        if (req.rd) begin
            if (req.is_ctrl)        st_d.rdata = st_q.ctrl;
            else if (req.is_falign) st_d.rdata = falign_in;
            else if (req.is_ofs)    st_d.rdata = st_q.ofs[req.ofs_idx];
            else if (req.is_cm)     st_d.rdata = cm_rdata;
        end
        if (req.wr) begin
            if (req.is_ctrl)     st_d.ctrl              = wdata;
            else if (req.is_ofs) st_d.ofs[req.ofs_idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q    = st_q.ctrl;
    assign ofs_q     = st_q.ofs;
    assign rvalid_q  = st_q.rvalid;
    assign rsrc_dm_q = st_q.rsrc_dm;
    assign rdata_q   = st_q.rdata;

    logic mapped;
    assign mapped = req.is_ctrl | req.is_falign | req.is_ofs | req.is_cm | req.is_dm;

    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req.rd |=> rvalid_q);  // R1

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req.wr && req.is_ctrl) |=> $stable(ctrl_q));  // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req.rd && !mapped) |=> (rdata_q == '0 && !rsrc_dm_q));  // R4

endmodule

// File: rtl/tsw_oe_ctrl.sv
module tsw_oe_ctrl #(
    parameter int NUM_STREAMS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ode,
    input  logic                   osb,
    input  logic                   oei,
    input  logic                   aoe,
    input  logic [NUM_STREAMS-1:0] slot_hiz,
    output logic [NUM_STREAMS-1:0] tx_oe,
    output logic [NUM_STREAMS-1:0] tx_ind,
    output logic [NUM_STREAMS-1:0] tx_is_ind
);

    typedef struct packed {
        logic [NUM_STREAMS-1:0] oe;
        logic [NUM_STREAMS-1:0] ind;
        logic [NUM_STREAMS-1:0] is_ind;
    } oe_st_t;

    oe_st_t st_d, st_q;
    logic   glob;
    logic [NUM_STREAMS-1:0] drv, oe_n, ind_n, is_n;

    assign glob = ode | osb;

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_line
        assign drv[s] = glob & ~slot_hiz[s];
        if (s % 2 == 1) begin : g_odd
            assign oe_n[s]  = (aoe | oei) ? glob : drv[s];
            assign is_n[s]  = aoe | oei;
            assign ind_n[s] = aoe ? drv[s] : (oei ? drv[s-1] : 1'b0);
        end else begin : g_even
            assign oe_n[s]  = aoe ? glob : drv[s];
            assign is_n[s]  = aoe;
            assign ind_n[s] = aoe ? drv[s] : 1'b0;
        end

        AST_HIZ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_hiz[s] && !oei && !aoe) |=> !tx_oe[s]);  // R6

        if (s % 2 == 1) begin : g_pair_chk
            AST_OEI_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
                (oei && !aoe) |=> (tx_is_ind[s] && !tx_is_ind[s-1]));  // R8
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.oe     = oe_n;
        st_d.ind    = ind_n;
        st_d.is_ind = is_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_oe     = st_q.oe;
    assign tx_ind    = st_q.ind;
    assign tx_is_ind = st_q.is_ind;

    AST_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !glob |=> (tx_oe == '0));  // R7

    AST_AOE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (aoe && glob) |=> ((&tx_oe) && (&tx_is_ind)));  // R9

endmodule

// File: rtl/tsw_host_oe.sv
module tsw_host_oe
    import tsw_host_pkg::*;
#(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 32,
    localparam int CH_IDX_W = $clog2(NUM_CHANNELS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       h_sel,
    input  logic                       h_we,
    input  logic [ADDR_W-1:0]          h_addr,
    input  logic [DATA_W-1:0]          h_wdata,
    output logic [DATA_W-1:0]          h_rdata,
    output logic                       h_rvalid,
    output logic                       dm_re,
    output logic [12:0]                dm_addr,
    input  logic [DATA_W-1:0]          dm_rdata,
    input  logic [DATA_W-1:0]          falign_in,
    output logic [DATA_W-1:0]          ctrl_out,
    output logic [NUM_OFS*DATA_W-1:0]  ofs_out,
    input  logic                       ode,
    input  logic [CH_IDX_W-1:0]        tx_slot,
    output logic [NUM_STREAMS-1:0]     tx_oe,
    output logic [NUM_STREAMS-1:0]     tx_ind,
    output logic [NUM_STREAMS-1:0]     tx_is_ind
);

    hreq_t                          req;
    logic [DATA_W-1:0]              cm_rdata;
    logic [NUM_STREAMS-1:0]         slot_hiz;
    logic [NUM_OFS-1:0][DATA_W-1:0] ofs_q;
    logic                           rsrc_dm_q;
    logic [DATA_W-1:0]              rdata_q;

    tsw_addr_decode #(
        .NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)
    ) u_dec (
        .sel(h_sel), .we(h_we), .addr(h_addr), .req(req)
    );

    tsw_connmem #(
        .NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)
    ) u_cm (
        .clk(clk), .wr_en(req.wr && req.is_cm), .rd_ok(req.is_cm),
        .strm(req.strm), .chan(req.chan), .wdata(h_wdata), .rdata(cm_rdata),
        .slot_chan(tx_slot), .slot_hiz(slot_hiz)
    );

    tsw_host_regs u_regs (
        .clk(clk), .rst_n(rst_n), .req(req), .wdata(h_wdata),
        .falign_in(falign_in), .cm_rdata(cm_rdata), .ctrl_q(ctrl_out),
        .ofs_q(ofs_q), .rvalid_q(h_rvalid), .rsrc_dm_q(rsrc_dm_q),
        .rdata_q(rdata_q)
    );

    tsw_oe_ctrl #(.NUM_STREAMS(NUM_STREAMS)) u_oe (
        .clk(clk), .rst_n(rst_n), .ode(ode),
        .osb(ctrl_out[CTRL_OSB]), .oei(ctrl_out[CTRL_OEI]), .aoe(ctrl_out[CTRL_AOE]),
        .slot_hiz(slot_hiz), .tx_oe(tx_oe), .tx_ind(tx_ind), .tx_is_ind(tx_is_ind)
    );

    assign ofs_out = ofs_q;
    assign dm_re   = req.rd && req.is_dm;
    assign dm_addr = h_addr[12:0];
    assign h_rdata = rsrc_dm_q ? dm_rdata : rdata_q;

endmodule

// File: tb/tb_tsw_host_oe.sv
`timescale 1ns/1ps
module tb_tsw_host_oe;
    localparam int NS = 4;
    localparam int NC = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_sel = 1'b0, h_we = 1'b0;
    logic [14:0] h_addr = '0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        h_rvalid;
    logic        dm_re;
    logic [12:0] dm_addr;
    logic [15:0] dm_rdata = '0;
    logic [15:0] falign_in = 16'hBEEF;
    logic [15:0] ctrl_out;
    logic [127:0] ofs_out;
    logic        ode = 1'b0;
    logic [4:0]  tx_slot = '0;
    logic [NS-1:0] tx_oe, tx_ind, tx_is_ind;

    int compared = 0, mismatched = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] cm_m [NS][NC];
    logic        b_ode = 1'b0;
    logic [15:0] b_ctrl = '0;

    always #2 clk = ~clk;

    tsw_host_oe #(.NUM_STREAMS(NS), .NUM_CHANNELS(NC)) dut (.*);

    // external data memory model: one-cycle read
    always @(posedge clk) if (dm_re) dm_rdata <= 16'h5A5A ^ {3'b0, dm_addr};

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && h_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected read data", 128'(h_rdata), 128'hDEAD_0000);
            end else begin
                check(tag_q.pop_front(), 128'(h_rdata), 128'(exp_q.pop_front()));
            end
        end
    end

    function automatic logic [14:0] cm_a(input int s, input int c);
        return {2'b10, 5'(s), 8'(c)};
    endfunction
    function automatic logic [14:0] rg_a(input int code);
        return {2'b01, 4'(code), 9'h0A5};
    endfunction

    task automatic host_wr(input logic [14:0] a, input logic [15:0] d);
        h_sel = 1; h_we = 1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_sel = 0; h_we = 0;
    endtask

    task automatic host_rd(input logic [14:0] a, input logic [15:0] e, input string tag);
        h_sel = 1; h_we = 0; h_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        h_sel = 0;
    endtask

    task automatic set_ctrl(input logic [15:0] v);
        host_wr(rg_a(0), v);
        b_ctrl = v;
    endtask

    task automatic check_oe(input int c, input string tag);
        logic [NS-1:0] d, eo, ei, es;
        logic g;
        tx_slot = 5'(c);
        @(negedge clk);
        g = b_ode | b_ctrl[0];
        for (int s = 0; s < NS; s++) d[s] = g && (cm_m[s][c][15:14] != 2'b11);
        eo = d; ei = '0; es = '0;
        if (b_ctrl[2]) begin
            eo = {NS{g}}; es = '1; ei = d;
        end else if (b_ctrl[1]) begin
            for (int s = 1; s < NS; s += 2) begin
                eo[s] = g; es[s] = 1'b1; ei[s] = d[s-1];
            end
        end
        check({tag, " R10 tx_oe"}, 128'(tx_oe), 128'(eo));
        check({tag, " tx_ind"}, 128'(tx_ind), 128'(ei));
        check({tag, " tx_is_ind"}, 128'(tx_is_ind), 128'(es));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R5 reset ctrl", 128'(ctrl_out), 0);
        check("R5 reset offsets", ofs_out, 0);
        check("R5 reset tx_oe", 128'(tx_oe), 0);
        check("R5 reset rvalid", 128'(h_rvalid), 0);

        // program connection memory with global enable low
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++) begin
                logic [1:0] m;
                m = ((s + c) % 3 == 0) ? 2'b11 : (((s + c) % 3 == 1) ? 2'b01 : 2'b00);
                cm_m[s][c] = {m, 14'(s * 37 + c)};
                host_wr(cm_a(s, c), cm_m[s][c]);
            end
        host_rd(cm_a(0, 0), cm_m[0][0], "R1 cm s0c0");
        host_rd(cm_a(3, 31), cm_m[3][31], "R1 cm s3c31");
        host_rd(cm_a(2, 17), cm_m[2][17], "R1 cm s2c17");

        // registers
        for (int k = 0; k < 8; k++) host_wr(rg_a(k + 2), 16'h1100 + 16'(k));
        @(negedge clk);
        for (int k = 0; k < 8; k++)
            check("R2 ofs_out", 128'(ofs_out[16*k +: 16]), 128'(16'h1100 + 16'(k)));
        host_rd(rg_a(5), 16'h1103, "R2 ofs3 read");
        set_ctrl(16'hA5F0);
        check("R2 ctrl_out", 128'(ctrl_out), 128'(16'hA5F0));
        host_rd(rg_a(0), 16'hA5F0, "R2 ctrl read");

        // read-only and forwarded areas
        host_rd(rg_a(1), 16'hBEEF, "R3 falign read");
        host_wr(rg_a(1), 16'h1234);
        host_rd(rg_a(1), 16'hBEEF, "R3 falign after write");
        h_sel = 1; h_we = 0; h_addr = {2'b11, 13'h0123};
        #0.5;
        check("R3 dm_re", 128'(dm_re), 1);
        check("R3 dm_addr", 128'(dm_addr), 128'(13'h0123));
        exp_q.push_back(16'h5A5A ^ 16'h0123); tag_q.push_back("R3 dm read");
        @(negedge clk); h_sel = 0;
        h_sel = 1; h_we = 1; h_addr = {2'b11, 13'h0040}; h_wdata = 16'hFFFF;
        #0.5;
        check("R3 dm write ignored dm_re", 128'(dm_re), 0);
        @(negedge clk); h_sel = 0; h_we = 0;
        check("R3 dm write ignored ctrl", 128'(ctrl_out), 128'(16'hA5F0));

        // unmapped
        host_rd(rg_a(10), 16'h0, "R4 code10 read");
        host_rd(rg_a(15), 16'h0, "R4 code15 read");
        host_wr(rg_a(12), 16'h7777);
        host_wr({2'b00, 13'h0000}, 16'h7777);
        check("R4 unmapped write ctrl", 128'(ctrl_out), 128'(16'hA5F0));
        check("R4 unmapped write ofs", ofs_out[15:0], 128'(16'h1100));
        host_rd({2'b00, 13'h0001}, 16'h0, "R4 area00 read");
        host_rd(cm_a(4, 0), 16'h0, "R4 cm stream range read");
        host_rd(cm_a(0, 40), 16'h0, "R4 cm channel range read");
        host_wr(cm_a(5, 0), 16'h7777);
        host_rd(cm_a(1, 0), cm_m[1][0], "R4 out-of-range write ignored");

        // output enable
        set_ctrl(16'h0000);
        for (int c = 0; c < 4; c++) check_oe(c, "R7 all off");
        b_ode = 1; ode = 1;
        for (int c = 0; c < 6; c++) check_oe(c, "R6 R7 ode");
        b_ode = 0; ode = 0;
        set_ctrl(16'h0001);
        for (int c = 6; c < 10; c++) check_oe(c, "R6 R7 osb");
        set_ctrl(16'h0003);
        for (int c = 0; c < 6; c++) check_oe(c, "R8 oei");
        set_ctrl(16'h0007);
        for (int c = 0; c < 4; c++) check_oe(c, "R9 aoe+oei");
        set_ctrl(16'h0004);
        for (int c = 0; c < 3; c++) check_oe(c, "R9 aoe idle");
        b_ode = 1; ode = 1;
        for (int c = 3; c < 6; c++) check_oe(c, "R9 aoe ode");
        set_ctrl(16'h0000);
        b_ode = 0; ode = 0;
        check_oe(12, "R10 after disable");

        // reset again: storage kept
        @(negedge clk);
        repeat (2) @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        set_ctrl(16'h0003);
        rst_n = 0; b_ctrl = 0;
        @(negedge clk);
        check("R5 reset tx_oe again", 128'(tx_oe), 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R5 ctrl cleared", 128'(ctrl_out), 0);
        host_rd(cm_a(2, 17), cm_m[2][17], "R5 cm kept");
        host_rd(cm_a(3, 5), cm_m[3][5], "R5 cm kept");
        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", 128'(exp_q.size()), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule